// File: doc/BRIEF.md
# Paged address translation mapper

This block widens the address reach of an 8-bit processor with a 16-bit address bus to a 20-bit system bus. The processor space is cut into sixteen 4 KB pages. A small table of sixteen 8-bit page numbers sits beside the processor. On each access the page field of the processor address selects one table entry. The complement of that entry becomes the upper eight bits of the outgoing address, and the 12-bit offset passes through unchanged. Translation is always on. It does not depend on how much memory is fitted.

Software loads the table by writing to the sixteen addresses at the very top of the processor map. Those writes never reach main memory. Reads of the same sixteen addresses are sent to system ROM instead, because that is where the reset and interrupt vectors live. The table therefore cannot be read back.

All outgoing signals are registered. They appear one clock after the processor presents a qualified access.

Top module: `pgmap_top`

## Requirements
- R1: While reset is held, and after it is released, all bus strobes are low and `bus_addr` is zero. Table entry i holds i, so page i translates to upper byte 0xFF minus i.
- R2: For an access presented with `cpu_valid` high, `bus_addr` on the next clock equals {~entry[cpu_addr[15:12]], cpu_addr[11:0]}. Here entry[] is the table content before that access.
- R3: Bits 11:0 of `bus_addr` always equal the offset bits of the access that produced them.
- R4: A write (`cpu_rw` = 0) to 0xFFF0..0xFFFF loads entry cpu_addr[3:0] with `cpu_wdata`. Every later access uses the new value. `cpu_rw` = 1 means read.
- R5: A table write raises neither `bus_wr` nor `bus_rd` nor `rom_rd`.
- R6: A read of 0xFFF0..0xFFFF raises `rom_rd` one clock later with `bus_rd` low. The table is unchanged.
- R7: A write outside the window raises `bus_wr` one clock later, with `bus_wdata` equal to the written byte. The table is unchanged.
- R8: A read outside the window raises `bus_rd` one clock later. `rom_rd` and `bus_wr` stay low.
- R9: A cycle with `cpu_valid` low leaves all strobes low on the next clock and keeps `bus_addr` and `bus_wdata` unchanged. The table does not change.
- R10: At most one of `bus_rd`, `bus_wr`, `rom_rd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_valid | input | 1 | Access qualifier for this cycle |
| bus_addr | output | 20 | Translated system bus address |
| bus_wdata | output | 8 | Write data for the system bus |
| bus_rd | output | 1 | Main-memory read strobe |
| bus_wr | output | 1 | Main-memory write strobe |
| rom_rd | output | 1 | ROM read strobe for the top window |

## Verification
The assertions assume that the processor inputs are settled at each rising edge. They also assume that `cpu_valid` stays low while reset is held. Their one-cycle `$past` checks are valid only under these two conditions. The stimulus changes inputs on falling edges and keeps `cpu_valid` low during reset. Random accesses are biased toward the top window so that table writes and ROM reads happen often. Idle cycles are mixed in at random to exercise the hold behaviour.

// File: rtl/pgmap_pkg.sv
// Package: shared sizes and the access classification type for the mapper.
// Assumes a power-of-two page count; all widths derive from the parameters.
package pgmap_pkg;
    parameter int CPU_AW    = 16;              // processor address width
    parameter int PAGE_BITS = 4;               // page-select bits
    parameter int PAGE_W    = 8;               // table entry width
    parameter int DATA_W    = 8;               // data width
    localparam int OFF_W    = CPU_AW - PAGE_BITS;
    localparam int BUS_AW   = PAGE_W + OFF_W;
    localparam int ENTRIES  = 1 << PAGE_BITS;
    localparam int WIN_W    = CPU_AW - PAGE_BITS;

    typedef enum logic [2:0] {
        ACC_IDLE = 3'd0,
        ACC_RD   = 3'd1,
        ACC_WR   = 3'd2,
        ACC_ROM  = 3'd3,
        ACC_TBL  = 3'd4
    } acc_kind_t;
endpackage

// File: rtl/pgmap_decode.sv
// Module: classifies one processor cycle as idle, memory read, memory write,
// ROM read of the top window, or table write. Purely combinational.
// Assumes cpu_rw = 1 means read; the top window is the last 2^PAGE_BITS bytes.
module pgmap_decode
    import pgmap_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_valid,
    output acc_kind_t         kind
);
    logic in_window;

    // Detect an address inside the table window.
    always_comb begin
        in_window = &cpu_addr[CPU_AW-1:PAGE_BITS];
    end

    // Pick the access class from qualifier, direction and window.
    always_comb begin
        if (!cpu_valid)      kind = ACC_IDLE;
        else if (cpu_rw)     kind = in_window ? ACC_ROM : ACC_RD;
        else                 kind = in_window ? ACC_TBL : ACC_WR;
    end
endmodule

// File: rtl/pgmap_table.sv
// Module: the page table. Holds ENTRIES words of PAGE_W bits and returns the
// complement of the selected entry. Entry i resets to i.
// Assumes one write port and one combinational read port.
module pgmap_table
    import pgmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [PAGE_BITS-1:0] widx,
    input  logic [PAGE_W-1:0]    wval,
    input  logic [PAGE_BITS-1:0] ridx,
    output logic [PAGE_W-1:0]    page_out
);
    logic [ENTRIES-1:0][PAGE_W-1:0] ent;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Hold one entry; load it on a matching table write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= PAGE_W'(g);
            else if (we && (widx == PAGE_BITS'(g)))
                ent[g] <= wval;
        end
    end

    // Read the selected entry and apply the output inversion.
    always_comb begin
        page_out = ~ent[ridx];
    end
endmodule

// File: rtl/pgmap_xlate.sv
// Module: forms the wide bus address from a page number and the CPU offset.
// Assumes page_num is already the inverted table output.
module pgmap_xlate
    import pgmap_pkg::*;
(
    input  logic [PAGE_W-1:0] page_num,
    input  logic [OFF_W-1:0]  offset,
    output logic [BUS_AW-1:0] wide_addr
);
    // Concatenate page and offset.
    always_comb begin
        wide_addr = {page_num, offset};
    end
endmodule

// File: rtl/pgmap_top.sv
// Module: paged address translation mapper top. Decodes each CPU cycle,
// translates through the page table and registers the bus outputs.
// Assumes inputs are stable at the rising edge; outputs lag one clock.
module pgmap_top
    import pgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rw,
    input  logic              cpu_valid,
    output logic [19:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              rom_rd
);
    acc_kind_t             kind;
    logic [PAGE_W-1:0]     page_num;
    logic [BUS_AW-1:0]     wide_addr;
    logic                  tbl_we;

    pgmap_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .cpu_valid(cpu_valid),
        .kind     (kind)
    );

    // Table write enable for a window write.
    always_comb begin
        tbl_we = (kind == ACC_TBL);
    end

    pgmap_table u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .widx    (cpu_addr[PAGE_BITS-1:0]),
        .wval    (cpu_wdata),
        .ridx    (cpu_addr[CPU_AW-1:OFF_W]),
        .page_out(page_num)
    );

    pgmap_xlate u_xl (
        .page_num (page_num),
        .offset   (cpu_addr[OFF_W-1:0]),
        .wide_addr(wide_addr)
    );

    // Register the translated address and write data on each valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (kind != ACC_IDLE) begin
            bus_addr  <= wide_addr;
            bus_wdata <= cpu_wdata;
        end
    end

    // Register the qualified strobes; table writes raise none.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd <= 1'b0;
            bus_wr <= 1'b0;
            rom_rd <= 1'b0;
        end else begin
            bus_rd <= (kind == ACC_RD);
            bus_wr <= (kind == ACC_WR);
            rom_rd <= (kind == ACC_ROM);
        end
    end
endmodule

// File: rtl/pgmap_checker.sv
// Module: temporal checks for pgmap_top, bound to every instance.
// Assumes cpu_valid is low while reset is held.
module pgmap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_rw,
    input logic        cpu_valid,
    input logic [19:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        rom_rd
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr, rom_rd}));                              // R10
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_valid) |-> bus_addr[11:0] == $past(cpu_addr[11:0]));   // R3
    AST_TBL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(cpu_addr[15:4]) != 12'hFFF);                     // R5
    AST_WIN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_valid && cpu_rw && cpu_addr[15:4] == 12'hFFF) |-> (rom_rd && !bus_rd)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_valid) |-> ($stable(bus_addr) && !bus_rd && !bus_wr && !rom_rd)); // R9
    AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_wdata == $past(cpu_wdata));                        // R7
endmodule

bind pgmap_top pgmap_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_rw   (cpu_rw),
    .cpu_valid(cpu_valid),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rom_rd   (rom_rd)
);

// File: tb/pgmap_top_tb_top.sv
// Bench: directed and seeded random accesses checked against a table model.
module pgmap_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_valid = 1'b0;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd, bus_wr, rom_rd;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [16];
    logic [19:0] last_addr = '0;
    logic [7:0]  last_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgmap_top dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .cpu_valid(cpu_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_rd(rom_rd)
    );

    function automatic logic [19:0] xl(input logic [15:0] a);
        return {~model[a[15:12]], a[11:0]};
    endfunction

    function automatic bit in_win(input logic [15:0] a);
        return a[15:4] == 12'hFFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge and check outputs at the next falling edge.
    task automatic access(input logic v, input logic rw, input logic [15:0] a,
                          input logic [7:0] d, input string req);
        logic [19:0] ea;
        logic [7:0]  ed;
        logic er, ew, eo;
        cpu_valid = v; cpu_rw = rw; cpu_addr = a; cpu_wdata = d;
        ea = v ? xl(a) : last_addr;
        ed = v ? d : last_wdata;
        er = v && rw && !in_win(a);
        ew = v && !rw && !in_win(a);
        eo = v && rw && in_win(a);
        @(negedge clk);
        chk({req, " addr"}, 32'(bus_addr), 32'(ea));
        chk({req, " rd"}, 32'(bus_rd), 32'(er));
        chk({req, " wr"}, 32'(bus_wr), 32'(ew));
        chk({req, " rom"}, 32'(rom_rd), 32'(eo));
        chk({req, " wdata"}, 32'(bus_wdata), 32'(ed));
        if (v && !rw && in_win(a)) model[a[3:0]] = d;
        last_addr = ea;
        last_wdata = ed;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) model[i] = 8'(i);
        repeat (4) @(negedge clk);
        // R1: reset state of strobes and address
        chk("R1 reset addr", 32'(bus_addr), 0);
        chk("R1 reset strobes", 32'({bus_rd, bus_wr, rom_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({bus_rd, bus_wr, rom_rd}), 0);
        // R1 R2: default map gives page 0xFF minus index
        for (int p = 0; p < 15; p++) begin
            access(1, 1, {4'(p), 12'h5A5}, 8'h00, "R1 default map");
            chk("R1 upper byte", 32'(bus_addr[19:12]), 32'(8'hFF - 8'(p)));
        end
        // R4 R5: program all entries through the window
        for (int i = 0; i < 16; i++)
            access(1, 0, 16'hFFF0 | 16'(i), 8'($urandom), "R4 R5 table write");
        // R2 R3 R8: translate a random offset in every page
        for (int p = 0; p < 16; p++)
            for (int k = 0; k < 3; k++)
                access(1, 1, {4'(p), 12'($urandom)}, 8'h00, "R2 R3 R8 translate");
        // R3 offset corners
        access(1, 1, 16'h3000, 8'h00, "R3 offset low");
        access(1, 1, 16'h3FFF, 8'h00, "R3 offset high");
        // R6: window reads go to ROM and leave the table alone
        access(1, 1, 16'hFFFE, 8'h00, "R6 vector read");
        access(1, 1, 16'hFFF3, 8'h00, "R6 window read");
        access(1, 1, 16'h3123, 8'h00, "R6 table kept");
        // R7: memory write outside the window, just below it
        access(1, 0, 16'hFFEF, 8'hC3, "R7 write below window");
        access(1, 1, 16'hF010, 8'h00, "R7 table kept");
        // R4: new value used on the very next access
        access(1, 0, 16'hFFF7, 8'h42, "R4 rewrite");
        access(1, 1, 16'h7ABC, 8'h00, "R4 immediate");
        chk("R4 upper byte", 32'(bus_addr[19:12]), 32'(8'hBD));
        // R9: idle cycles hold and do not write the table
        access(0, 0, 16'hFFF7, 8'h99, "R9 idle");
        access(0, 1, 16'h1234, 8'h00, "R9 idle");
        access(1, 1, 16'h7001, 8'h00, "R9 table kept");
        // Random mix, biased toward the window
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = ($urandom % 3 == 0) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
            access(($urandom % 5) != 0, $urandom % 2 == 1, a, 8'($urandom), "R2 R10 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule